// File: doc/BRIEF.md
# Paged Register File with Pointer-Based Addressing

This block holds a 4096-byte register store and turns three address forms into one full 12-bit byte address. A caller can give a full 12-bit address, an 8-bit offset inside the current 256-byte page, or a 4-bit index inside the current 16-register group. An 8-bit register pointer picks the current page and group. Its low nibble selects the page. Its high nibble selects the group within that page.

Each access reads or writes either one byte or a 16-bit pair. Writes take effect on the rising clock edge. Read data is registered and appears one cycle after the request, marked by a valid strobe. A separate pointer-load input replaces the pointer value, in the way a set-pointer instruction would. That load takes effect at the same clock edge as any register access presented with it. The access itself still uses the pointer value from before the load.

Top module: `paged_regfile`

## Requirements
- R1: On reset (rst_n low at a rising edge) the pointer output ptr_q becomes 0x00 and rd_valid becomes 0. The storage contents are not cleared.
- R2: With acc_mode = 2'b00 (linear), the byte address is acc_addr[11:0] exactly, whatever the pointer holds.
- R3: With acc_mode = 2'b01 (page), the byte address is {ptr_q[3:0], acc_addr[7:0]}, and acc_addr[11:8] has no effect.
- R4: With acc_mode = 2'b10 (working group), the byte address is {ptr_q[3:0], ptr_q[7:4], acc_addr[3:0]}, and acc_addr[11:4] has no effect.
- R5: When ptr_ld is high at a rising edge, ptr_q takes ptr_din. Otherwise ptr_q holds its value. Later page and group accesses use the new value.
- R6: When a pointer load and a register access happen in the same cycle, both complete, and the access uses the pointer value from before the load.
- R7: A read (acc_req = 1, acc_we = 0) raises rd_valid exactly one cycle later with its data on rd_data. rd_valid is 0 in every other cycle.
- R8: A byte write (acc_pair = 0) stores wr_data[7:0] at the formed address and leaves every other byte unchanged. A byte read returns {8'h00, byte}.
- R9: A pair access (acc_pair = 1) clears bit 0 of the formed address. The high byte (wr_data[15:8] / rd_data[15:8]) is at that even address and the low byte is at the next address.
- R10: acc_mode = 2'b11 is reserved and is handled exactly as linear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_ld | input | 1 | Load ptr_din into the register pointer |
| ptr_din | input | 8 | New pointer value |
| ptr_q | output | 8 | Current pointer: [3:0] page, [7:4] group |
| acc_req | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_mode | input | 2 | 00 linear, 01 page, 10 working, 11 reserved (linear) |
| acc_pair | input | 1 | 1 = 16-bit pair, 0 = byte |
| acc_addr | input | 12 | Raw address; width used depends on the mode |
| wr_data | input | 16 | Write data; a byte write uses [7:0] |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of last cycle's read |

## Verification
The checker tests three things on every cycle. It compares the formed address against each mode's rule. It checks that the pointer loads only when asked and holds otherwise. It checks that rd_valid follows a read by exactly one cycle. Whether the right bytes end up in the right places can only be shown by the bench's scenarios. These cover pair byte order and the forced-even alignment, whether a byte write leaves its neighbour untouched, and whether a write issued alongside a pointer load lands under the old pointer.

// File: rtl/prf_pkg.sv
// Shared types for the paged register file.
// Assumes: the mode field is two bits wide, and its encoding is fixed by the requirements.
package prf_pkg;
    typedef enum logic [1:0] {
        AM_LINEAR = 2'b00,
        AM_PAGE   = 2'b01,
        AM_WORK   = 2'b10,
        AM_RSVD   = 2'b11
    } amode_e;
endpackage

// File: rtl/prf_ptr_reg.sv
// Register pointer. The low half selects the page and the high half selects the
// working group. Assumes: synchronous active-low reset to zero.
module prf_ptr_reg #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PTR_W-1:0] din,
    output logic [PTR_W-1:0] q
);
    // Hold the pointer; replace it on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= din;
    end
endmodule

// File: rtl/prf_addr_form.sv
// Forms the full byte address from the raw address, the mode and the pointer.
// Assumes: ADDR_W - PTR_W/2 is the page offset width, and that offset is wider
// than one pointer nibble, so a group offset remains.
module prf_addr_form
    import prf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 8
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              pair,
    output logic [ADDR_W-1:0] phys_addr
);
    localparam int NIB_W   = PTR_W / 2;
    localparam int PG_OFF  = ADDR_W - NIB_W;
    localparam int GRP_OFF = PG_OFF - NIB_W;

    logic [ADDR_W-1:0] formed;

    // Pick the address form that the mode selects.
    always_comb begin
        case (amode_e'(mode))
            AM_PAGE: formed = {ptr[NIB_W-1:0], raw_addr[PG_OFF-1:0]};
            AM_WORK: formed = {ptr[NIB_W-1:0], ptr[PTR_W-1:NIB_W], raw_addr[GRP_OFF-1:0]};
            default: formed = raw_addr;
        endcase
    end

    // A pair access is aligned to an even address.
    always_comb begin
        phys_addr = formed;
        if (pair) phys_addr[0] = 1'b0;
    end
endmodule

// File: rtl/prf_bank_store.sv
// Byte storage split into an even bank and an odd bank, so that a pair access
// touches one row of each bank in a single cycle. Assumes: the address is
// already even for pair accesses. The contents are not reset.
module prf_bank_store #(
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic                pair,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2*BYTE_W-1:0] wdata,
    output logic [2*BYTE_W-1:0] rdata,
    output logic                rvalid
);
    localparam int ROW_W = ADDR_W - 1;
    localparam int ROWS  = 1 << ROW_W;

    logic [ROW_W-1:0]  row;
    logic              odd;
    logic [BYTE_W-1:0] bank_q [2];
    logic              pair_q;
    logic              odd_q;

    assign row = addr[ADDR_W-1:1];
    assign odd = addr[0];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [BYTE_W-1:0] mem [ROWS];
        logic              wen;
        logic [BYTE_W-1:0] wbyte;

        // A bank is written by any pair write, or by a byte write to its own parity.
        assign wen   = req && we && (pair || (odd == (b == 1)));
        assign wbyte = (pair && b == 0) ? wdata[2*BYTE_W-1:BYTE_W] : wdata[BYTE_W-1:0];

        // Store one byte per cycle into this bank.
        always_ff @(posedge clk) begin
            if (wen) mem[row] <= wbyte;
        end

        // Registered read of this bank's row.
        always_ff @(posedge clk) begin
            if (req && !we) bank_q[b] <= mem[row];
        end
    end

    // Remember the shape of the read so that the output can be assembled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            pair_q <= 1'b0;
            odd_q  <= 1'b0;
        end else begin
            rvalid <= req && !we;
            if (req && !we) begin
                pair_q <= pair;
                odd_q  <= odd;
            end
        end
    end

    // Return the high byte first for a pair, and a zero-extended byte otherwise.
    always_comb begin
        if (pair_q) rdata = {bank_q[0], bank_q[1]};
        else        rdata = {{BYTE_W{1'b0}}, (odd_q ? bank_q[1] : bank_q[0])};
    end
endmodule

// File: rtl/paged_regfile.sv
// Top level: a paged register file reached through linear, page or working-group
// addresses. Assumes: at most one access per cycle. A pointer load in the same
// cycle takes effect after that access.
module paged_regfile #(
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ptr_ld,
    input  logic [PTR_W-1:0]    ptr_din,
    output logic [PTR_W-1:0]    ptr_q,
    input  logic                acc_req,
    input  logic                acc_we,
    input  logic [1:0]          acc_mode,
    input  logic                acc_pair,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [2*BYTE_W-1:0] wr_data,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic                rd_valid
);
    logic [ADDR_W-1:0] phys_addr;

    prf_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (ptr_ld),
        .din  (ptr_din),
        .q    (ptr_q)
    );

    prf_addr_form #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_form (
        .mode     (acc_mode),
        .raw_addr (acc_addr),
        .ptr      (ptr_q),
        .pair     (acc_pair),
        .phys_addr(phys_addr)
    );

    prf_bank_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (acc_req),
        .we    (acc_we),
        .pair  (acc_pair),
        .addr  (phys_addr),
        .wdata (wr_data),
        .rdata (rd_data),
        .rvalid(rd_valid)
    );
endmodule

// File: rtl/paged_regfile_chk.sv
// Cycle-level checks for paged_regfile, attached with bind.
module paged_regfile_chk #(
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_ld,
    input logic [PTR_W-1:0]  ptr_din,
    input logic [PTR_W-1:0]  ptr_q,
    input logic              acc_req,
    input logic              acc_we,
    input logic [1:0]        acc_mode,
    input logic              acc_pair,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              rd_valid
);
    localparam int NIB_W  = PTR_W / 2;
    localparam int PG_OFF = ADDR_W - NIB_W;
    localparam int GR_OFF = PG_OFF - NIB_W;

    p_reset_ptr_r1: assert property (@(posedge clk) !rst_n |=> (ptr_q == '0 && !rd_valid));

    p_linear_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_pair && acc_mode == 2'b00) |-> phys_addr == acc_addr);

    p_rsvd_form_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_pair && acc_mode == 2'b11) |-> phys_addr == acc_addr);

    p_page_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_pair && acc_mode == 2'b01)
        |-> phys_addr == {ptr_q[NIB_W-1:0], acc_addr[PG_OFF-1:0]});

    p_work_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_pair && acc_mode == 2'b10)
        |-> phys_addr == {ptr_q[NIB_W-1:0], ptr_q[PTR_W-1:NIB_W], acc_addr[GR_OFF-1:0]});

    p_pair_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_pair) |-> !phys_addr[0]);

    p_ptr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld |=> ptr_q == $past(ptr_din));

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_ld |=> $stable(ptr_q));

    p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_we) |=> rd_valid);

    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && !acc_we) |=> !rd_valid);
endmodule

bind paged_regfile paged_regfile_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_ld   (ptr_ld),
    .ptr_din  (ptr_din),
    .ptr_q    (ptr_q),
    .acc_req  (acc_req),
    .acc_we   (acc_we),
    .acc_mode (acc_mode),
    .acc_pair (acc_pair),
    .acc_addr (acc_addr),
    .phys_addr(phys_addr),
    .rd_valid (rd_valid)
);

// File: tb/paged_regfile_bench.sv
module paged_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_ld = 1'b0;
    logic [7:0]  ptr_din = '0;
    logic [7:0]  ptr_q;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic [1:0]  acc_mode = '0;
    logic        acc_pair = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] d;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    logic [7:0]  mdl [int];
    logic [7:0]  mptr = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_regfile u_paged_regfile (
        .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_din(ptr_din), .ptr_q(ptr_q),
        .acc_req(acc_req), .acc_we(acc_we), .acc_mode(acc_mode), .acc_pair(acc_pair),
        .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [11:0] form(logic [1:0] m, logic [11:0] a, logic [7:0] p);
        case (m)
            2'b01:   return {p[3:0], a[7:0]};
            2'b10:   return {p[3:0], p[7:4], a[3:0]};
            default: return a;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Driver: present one cycle of stimulus and record the expected outcome.
    task automatic drive(input logic rq, input logic w, input logic [1:0] m,
                         input logic [11:0] a, input logic pr, input logic [15:0] wd,
                         input logic ld, input logic [7:0] pd, input string tag);
        logic [11:0] pa;
        exp_t        e;
        @(negedge clk);
        acc_req = rq; acc_we = w; acc_mode = m; acc_addr = a; acc_pair = pr;
        wr_data = wd; ptr_ld = ld; ptr_din = pd;
        pa = form(m, a, mptr);
        if (pr) pa[0] = 1'b0;
        if (rq && w) begin
            if (pr) begin
                mdl[int'(pa)]     = wd[15:8];
                mdl[int'(pa) + 1] = wd[7:0];
            end else begin
                mdl[int'(pa)] = wd[7:0];
            end
        end else if (rq) begin
            e.d   = pr ? {mdl[int'(pa)], mdl[int'(pa) + 1]} : {8'h00, mdl[int'(pa)]};
            e.tag = tag;
            sbq.push_back(e);
        end
        if (ld) mptr = pd;
    endtask

    task automatic wr(input logic [1:0] m, input logic [11:0] a, input logic pr,
                      input logic [15:0] wd);
        drive(1'b1, 1'b1, m, a, pr, wd, 1'b0, 8'h00, "");
    endtask

    task automatic rd(input logic [1:0] m, input logic [11:0] a, input logic pr,
                      input string tag);
        drive(1'b1, 1'b0, m, a, pr, 16'h0000, 1'b0, 8'h00, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_req = 1'b0; ptr_ld = 1'b0;
    endtask

    // Monitor: compare each read result against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sbq.size() == 0) begin
                check("R7 unexpected rd_valid", 16'h0001, 16'h0000);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(e.tag, rd_data, e.d);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ptr_q after reset", {8'h00, ptr_q}, 16'h0000);
        check("R1 rd_valid after reset", {15'h0, rd_valid}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        wr(2'b00, 12'h123, 1'b0, 16'h00A5);
        wr(2'b00, 12'h210, 1'b0, 16'h005A);
        rd(2'b00, 12'h123, 1'b0, "R2 R8 linear byte read");

        drive(1'b0, 1'b0, 2'b00, 12'h000, 1'b0, 16'h0, 1'b1, 8'h51, "");
        idle();
        check("R5 ptr_q after load", {8'h00, ptr_q}, 16'h0051);

        wr(2'b01, 12'h034, 1'b0, 16'h003C);
        rd(2'b00, 12'h134, 1'b0, "R3 page write lands on page 1");
        rd(2'b01, 12'hF34, 1'b0, "R3 page read ignores upper bits");

        wr(2'b10, 12'h007, 1'b0, 16'h0077);
        rd(2'b00, 12'h157, 1'b0, "R4 working write at page1 group5");
        rd(2'b10, 12'hFF7, 1'b0, "R4 working read ignores upper bits");
        rd(2'b00, 12'h123, 1'b0, "R2 linear unaffected by pointer");

        wr(2'b00, 12'h201, 1'b1, 16'hBEEF);
        rd(2'b00, 12'h200, 1'b0, "R9 pair high byte at even address");
        rd(2'b00, 12'h201, 1'b0, "R9 pair low byte at odd address");
        rd(2'b00, 12'h200, 1'b1, "R9 pair read even");
        rd(2'b00, 12'h201, 1'b1, "R9 pair read odd address aligned");

        wr(2'b00, 12'h200, 1'b0, 16'hFF42);
        rd(2'b00, 12'h200, 1'b1, "R8 byte write keeps neighbour");

        rd(2'b11, 12'h123, 1'b0, "R10 reserved mode read as linear");
        wr(2'b11, 12'h3FF, 1'b0, 16'h0011);
        rd(2'b00, 12'h3FF, 1'b0, "R10 reserved mode write as linear");

        drive(1'b1, 1'b1, 2'b01, 12'h010, 1'b0, 16'h0099, 1'b1, 8'hA2, "");
        idle();
        check("R5 R6 ptr_q after load with write", {8'h00, ptr_q}, 16'h00A2);
        rd(2'b00, 12'h110, 1'b0, "R6 write used old pointer");
        rd(2'b01, 12'h010, 1'b0, "R6 later page read uses new pointer");

        wr(2'b10, 12'h003, 1'b0, 16'h00C3);
        rd(2'b00, 12'h2A3, 1'b0, "R4 working write at page2 groupA");
        wr(2'b10, 12'h00F, 1'b1, 16'h1234);
        rd(2'b00, 12'h2AE, 1'b0, "R9 working pair high byte");
        rd(2'b00, 12'h2AF, 1'b0, "R9 working pair low byte");

        drive(1'b1, 1'b0, 2'b10, 12'h003, 1'b0, 16'h0, 1'b1, 8'h00, "R6 read with load uses old pointer");
        idle();
        check("R5 ptr_q cleared by load", {8'h00, ptr_q}, 16'h0000);
        idle();
        check("R7 rd_valid low when idle", {15'h0, rd_valid}, 16'h0000);
        idle();
        check("R7 every read returned", sbq.size()[15:0], 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule